// File: doc/BRIEF.md
# Transmit Bit Oversampling Replicator

This block widens a slow transmit stream so that it fits a transceiver running at one fixed word rate. A parallel word arrives with a strobe on only one clock in every x. The block repeats every bit of that word x times and packs the result into consecutive output words of the same width, one word per clock. All logic runs on a single clock.

The factor x comes from a 3-bit standard code that is sampled only on an input strobe. Standard-definition traffic uses 11 and high-definition traffic uses 2. A 3G stream on a 12G-capable link uses 4, and a 6G stream uses 2. Every other code selects a factor of 1, which passes each word through unchanged. Output bits are sent LSB first: input bit 0 fills the first x stream positions, input bit 1 fills the next x, and so on. Stream position n sits at bit n mod W of output word floor(n / W) after the strobe.

Top module: `ovs_replicator`

## Requirements
- R1: While reset is held and after reset is released, `valid_o` is 0 and `data_o` is all zeros until the first strobe is captured.
- R2: For the clocks after a strobe, stream bit n equals captured input bit floor(n / x). Output word k, counted from 0 on the clock after the strobe, carries stream bits k*W to k*W+W-1, with bit k*W at position 0.
- R3: Standard code 3'd0 selects x = 11, so one word spans 11 output words.
- R4: Standard codes 3'd1 and 3'd3 select x = 2.
- R5: Standard code 3'd2 selects x = 4.
- R6: Standard codes 3'd4 to 3'd7 select x = 1. `data_o` then equals the word captured on the previous clock.
- R7: `valid_o` is 1 on every clock from the clock after the first strobe until reset.
- R8: If no new strobe arrives after all x output words of a captured word have been sent, the stream wraps and sends the same word again from output word 0.
- R9: A change on `std_i` with no strobe has no effect on the output. The new factor applies from the next strobe.
- R10: A strobe always restarts the stream at output word 0 with the newly captured word, even if the previous word is unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by input and output |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | W | Input word |
| valid_i | input | 1 | Input strobe; captures `data_i` and `std_i` |
| std_i | input | 3 | Standard code that selects the factor |
| data_o | output | W | Replicated output word |
| valid_o | output | 1 | Output valid |

## Verification
The bench builds the block with W = 10. With this width, the run lengths of 4 and 11 cross word boundaries at uneven offsets, so ordering errors at word edges show up as mismatches. The bench covers:
- every standard code, including two codes that map to the pass-through factor, with back-to-back strobes at factor 1;
- idle stretches that force a wrap;
- a change of standard between strobes;
- an early strobe that cuts a stream short.

Each output word is compared with a bit-queue model on every clock.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  localparam int NUM_F = 4;
  localparam int FACT [NUM_F] = '{1, 2, 4, 11};
  localparam int MAX_F = 11;
  localparam int IDX_W = $clog2(MAX_F);
  localparam int SEL_W = $clog2(NUM_F);

  typedef enum logic [2:0] {
    STD_SD    = 3'd0,
    STD_HD    = 3'd1,
    STD_3G_12 = 3'd2,
    STD_6G    = 3'd3
  } std_code_e;

  function automatic logic [SEL_W-1:0] std_to_sel(input logic [2:0] std);
    case (std)
      STD_SD:         return SEL_W'(3);
      STD_HD, STD_6G: return SEL_W'(1);
      STD_3G_12:      return SEL_W'(2);
      default:        return SEL_W'(0);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] sel_last(input logic [SEL_W-1:0] sel);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_F; i++)
      if (sel == SEL_W'(i)) r = IDX_W'(FACT[i] - 1);
    return r;
  endfunction
endpackage

// File: rtl/ovs_ctrl.sv
module ovs_ctrl
  import ovs_pkg::*;
#(
  parameter int W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     data_i,
  input  logic             valid_i,
  input  logic [2:0]       std_i,
  output logic [W-1:0]     hold_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             run_o
);
  logic [W-1:0]     hold_q;
  logic [SEL_W-1:0] sel_q;
  logic [IDX_W-1:0] idx_q;
  logic             run_q;
  logic [IDX_W-1:0] last;

  assign last = sel_last(sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      sel_q  <= '0;
      idx_q  <= '0;
      run_q  <= 1'b0;
    end else if (valid_i) begin
      hold_q <= data_i;
      sel_q  <= std_to_sel(std_i);
      idx_q  <= '0;
      run_q  <= 1'b1;
    end else if (run_q) begin
      idx_q <= (idx_q == last) ? '0 : idx_q + 1'b1;
    end
  end

  assign hold_o = hold_q;
  assign sel_o  = sel_q;
  assign idx_o  = idx_q;
  assign run_o  = run_q;

  a_r7_run_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);
  a_r10_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (idx_q == '0));
  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && run_q && idx_q == last) |=> (idx_q == '0));
  a_r9_sel_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sel_q) && $stable(hold_q));
  a_r2_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= last);
endmodule

// File: rtl/ovs_pack.sv
module ovs_pack
  import ovs_pkg::*;
#(
  parameter int W = 20,
  parameter int F = 2
) (
  input  logic [W-1:0]     hold_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [W-1:0]     word_o
);
  logic [W-1:0] words [F];

  // stream bit k*W+j takes input bit (k*W+j)/F
  for (genvar k = 0; k < F; k++) begin : g_word
    for (genvar j = 0; j < W; j++) begin : g_bit
      assign words[k][j] = hold_i[(k*W + j) / F];
    end
  end

  always_comb begin
    word_o = words[0];
    for (int k = 1; k < F; k++)
      if (idx_i == IDX_W'(k)) word_o = words[k];
  end
endmodule

// File: rtl/ovs_replicator.sv
module ovs_replicator
  import ovs_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         valid_i,
  input  logic [2:0]   std_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);
  logic [W-1:0]     hold;
  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] idx;
  logic             run;
  logic [W-1:0]     lane [NUM_F];

  ovs_ctrl #(.W(W)) i_ctrl (
    .clk_i, .rst_ni, .data_i, .valid_i, .std_i,
    .hold_o(hold), .sel_o(sel), .idx_o(idx), .run_o(run)
  );

  for (genvar f = 0; f < NUM_F; f++) begin : g_lane
    ovs_pack #(.W(W), .F(FACT[f])) i_pack (
      .hold_i(hold), .idx_i(idx), .word_o(lane[f])
    );
  end

  always_comb begin
    data_o = lane[0];
    for (int f = 1; f < NUM_F; f++)
      if (sel == SEL_W'(f)) data_o = lane[f];
  end

  assign valid_o = run;

  a_r6_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && std_i[2]) |=> (data_o == $past(data_i)));
  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (data_o == '0));
endmodule

// File: tb/test_ovs_replicator.sv
module test_ovs_replicator;
  localparam int W = 10;
  localparam int MAXF = 11;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         valid_i = 1'b0;
  logic [2:0]   std_i = 3'd0;
  logic [W-1:0] data_o;
  logic         valid_o;

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;
  string tag = "R1";

  bit mb [W*MAXF];
  int mx = 1, mptr = 0;
  bit mrun = 0;

  always #2.5 clk_i = ~clk_i;

  ovs_replicator #(.W(W)) i_ovs_replicator (.*);

  function automatic int fac(input logic [2:0] s);
    case (s)
      3'd0: return 11;
      3'd1, 3'd3: return 2;
      3'd2: return 4;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mrun = 0; mptr = 0; mx = 1;
      for (int n = 0; n < W*MAXF; n++) mb[n] = 0;
    end else if (valid_i) begin
      mx = fac(std_i);
      for (int n = 0; n < W*mx; n++) mb[n] = data_i[n/mx];
      mptr = 0; mrun = 1;
    end else if (mrun) begin
      mptr += W;
      if (mptr >= W*mx) mptr = 0;
    end
  end

  always @(negedge clk_i) if (!done) begin
    logic [W-1:0] e;
    for (int j = 0; j < W; j++) e[j] = mb[mptr+j];
    n_chk++;
    if (valid_o !== mrun) begin
      n_bad++;
      $display("FAIL %s/R7 valid_o act=%0b exp=%0b", tag, valid_o, mrun);
    end
    n_chk++;
    if (data_o !== e) begin
      n_bad++;
      $display("FAIL %s data_o act=%h exp=%h", tag, data_o, e);
    end
  end

  task automatic send(input logic [2:0] s, input int gap);
    @(negedge clk_i);
    data_i = W'($urandom); std_i = s; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (gap - 2) @(negedge clk_i);
  endtask

  task automatic burst(input logic [2:0] s, input int cnt, input string t);
    tag = t;
    for (int i = 0; i < cnt; i++) send(s, fac(s));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    burst(3'd0, 3, "R2_R3");
    burst(3'd1, 4, "R4");
    burst(3'd3, 3, "R4");
    burst(3'd2, 4, "R5");
    tag = "R6";
    @(negedge clk_i);
    for (int i = 0; i < 5; i++) begin
      data_i = W'($urandom); std_i = (i % 2) ? 3'd7 : 3'd4; valid_i = 1'b1;
      @(negedge clk_i);
    end
    valid_i = 1'b0;
    tag = "R8";
    send(3'd2, 14);
    send(3'd0, 25);
    tag = "R9";
    @(negedge clk_i);
    data_i = W'($urandom); std_i = 3'd0; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    std_i = 3'd1;
    repeat (7) @(negedge clk_i);
    burst(3'd1, 2, "R9");
    tag = "R10";
    @(negedge clk_i);
    data_i = W'($urandom); std_i = 3'd0; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    burst(3'd2, 2, "R10");
    repeat (3) @(negedge clk_i);
    done = 1;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp<=5000 cycles", cycles);
      done = 1;
    end
  end

  initial begin
    wait (done);
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule